// File: doc/BRIEF.md
# Banked Interrupt Controller with Round-Robin Finder

This block collects 128 interrupt request lines and holds each as a pending flag until software acknowledges it. The lines are split into four banks of 32. Each bank has four word registers on a simple 32-bit register bus: a read-only pending view, a write-one-to-acknowledge port, an enable mask and a routing select. The select sends each enabled pending source either to the ordinary interrupt output or to the fast interrupt output.

A combinational round-robin finder scans the enabled pending sources. It starts one past a software-written "last serviced" index and wraps through all 128 sources. It reports the first hit as a valid flag and a 7-bit index. Because software writes back the index it has just serviced, a source that keeps firing cannot starve the sources after it.

Top module: `ic_top`

## Requirements
- R1: After synchronous reset, all pending, enable and routing bits are 0. `irq_o` and `fiq_o` are 0, and the last-serviced register reads 127, so the first search begins at source 0.
- R2: A 0-to-1 transition on `src_i[k]` sets pending bit k on the next clock edge. A level held high does not set the bit again once it has been acknowledged.
- R3: A write to byte offset 16·n+4 clears every pending bit of bank n whose data bit is 1. Bits written 0 are unchanged, and this offset reads as 0.
- R4: When a rising edge and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R5: The enable mask lives at offset 16·n+8, where 1 enables a source. `irq_o` is the OR over all sources of pending AND enabled AND NOT routed-fast.
- R6: The routing select lives at offset 16·n+12, where 1 routes a source to `fiq_o`. `fiq_o` is the OR over all sources of pending AND enabled AND routed-fast.
- R7: Offset 16·n+0 returns bank n's pending bits, and writes to it have no effect.
- R8: `next_idx_o` is the first source that is pending and enabled, scanning from (last+1) mod 128 upward and wrapping past 127 to 0.
- R9: When no source is both pending and enabled, `next_valid_o` is 0 and `next_idx_o` is 0.
- R10: The last-serviced register sits at byte offset 64 and holds 7 bits, which are write data bits 6:0. Every other offset, and any address with bits 1:0 nonzero, reads as 0.
- R11: Source k maps to bank k>>5, bit k&31, in all four of that bank's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 128 | Interrupt request lines, edge detected |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |
| next_valid_o | output | 1 | Finder found a pending enabled source |
| next_idx_o | output | 7 | Index found by the finder |

## Verification
A single source is pulsed in a middle bank to confirm the bank and bit mapping. The same source is then exercised with its enable off, with its enable on, and with fast routing on, which separates the two output paths from each other and from the masking. The finder is fed four pending sources spread across the banks, with the last-serviced value placed just before each one and finally at the top end, so a start-offset error, a missed wrap and a scan in the wrong direction each yield a different index. Acknowledge writes are tried with zero data, against a held-high level, and in the same cycle as a new edge, which tells clear-wins apart from set-wins.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int N_BANKS  = 4;
    localparam int BANK_W   = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int N_SRC    = N_BANKS * BANK_W;
    localparam int IDX_W    = $clog2(N_SRC);
    localparam int SLOT_LSB = 4;
    localparam int SLOT_W   = ADDR_W - SLOT_LSB;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_ENABLE = 2'd2,
        REG_FAST   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic do_clr;
        logic do_en;
        logic do_fast;
    } bank_wr_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } rr_result_t;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] v);
        if (v == IDX_W'(N_SRC - 1))
            return '0;
        return v + 1'b1;
    endfunction
endpackage

// File: rtl/ic_bank.sv
module ic_bank
    import ic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] src,
    input  bank_wr_t          wr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] status,
    output logic [BANK_W-1:0] enable,
    output logic [BANK_W-1:0] fast,
    output logic              irq_any,
    output logic              fiq_any
);
    logic [BANK_W-1:0] src_q;
    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] clr;

    assign rise = src & ~src_q;
    assign clr  = wr.do_clr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            status <= '0;
            enable <= '0;
            fast   <= '0;
        end else begin
            src_q  <= src;
            // new edge wins over a simultaneous acknowledge
            status <= (status & ~clr) | rise;
            if (wr.do_en)
                enable <= wdata;
            if (wr.do_fast)
                fast <= wdata;
        end
    end

    assign irq_any = |(status & enable & ~fast);
    assign fiq_any = |(status & enable & fast);
endmodule

// File: rtl/ic_rr_finder.sv
module ic_rr_finder
    import ic_pkg::*;
(
    input  logic [N_SRC-1:0] pend,
    input  logic [IDX_W-1:0] last,
    output rr_result_t       res
);
    logic [IDX_W-1:0] start;
    logic [N_SRC-1:0] rot;
    logic [IDX_W-1:0] pos;
    logic             found;
    logic [IDX_W:0]   sum;

    assign start = wrap_inc(last);
    assign rot   = N_SRC'({pend, pend} >> start);

    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (rot[i]) begin
                found = 1'b1;
                pos   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        sum = {1'b0, start} + {1'b0, pos};
        if (sum >= (IDX_W + 1)'(N_SRC))
            sum = sum - (IDX_W + 1)'(N_SRC);
        res.valid = found;
        res.idx   = found ? sum[IDX_W-1:0] : '0;
    end
endmodule

// File: rtl/ic_top.sv
module ic_top
    import ic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              next_valid_o,
    output logic [IDX_W-1:0]  next_idx_o
);
    logic [SLOT_W-1:0] slot;
    reg_sel_e          sel;
    logic              aligned;

    assign slot    = bus_addr[ADDR_W-1:SLOT_LSB];
    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);

    bank_wr_t          bwr      [N_BANKS];
    logic [BANK_W-1:0] stat_w   [N_BANKS];
    logic [BANK_W-1:0] en_w     [N_BANKS];
    logic [BANK_W-1:0] fast_w   [N_BANKS];
    logic [N_BANKS-1:0] irq_b;
    logic [N_BANKS-1:0] fiq_b;
    logic [N_SRC-1:0]  stat_all;
    logic [N_SRC-1:0]  en_all;
    logic [N_SRC-1:0]  fast_all;
    logic [N_SRC-1:0]  pend_all;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = bus_wr && aligned && (slot == SLOT_W'(b));
        assign bwr[b].do_clr  = hit && (sel == REG_CLEAR);
        assign bwr[b].do_en   = hit && (sel == REG_ENABLE);
        assign bwr[b].do_fast = hit && (sel == REG_FAST);

        ic_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .src     (src_i[b*BANK_W +: BANK_W]),
            .wr      (bwr[b]),
            .wdata   (bus_wdata),
            .status  (stat_w[b]),
            .enable  (en_w[b]),
            .fast    (fast_w[b]),
            .irq_any (irq_b[b]),
            .fiq_any (fiq_b[b])
        );

        assign stat_all[b*BANK_W +: BANK_W] = stat_w[b];
        assign en_all  [b*BANK_W +: BANK_W] = en_w[b];
        assign fast_all[b*BANK_W +: BANK_W] = fast_w[b];
    end

    assign pend_all = stat_all & en_all;
    assign irq_o    = |irq_b;
    assign fiq_o    = |fiq_b;

    // last-serviced index register, one slot past the banks
    logic [IDX_W-1:0] last_q;
    logic             last_hit;
    assign last_hit = aligned && (slot == SLOT_W'(N_BANKS)) && (sel == REG_STATUS);

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= IDX_W'(N_SRC - 1);
        else if (bus_wr && last_hit)
            last_q <= bus_wdata[IDX_W-1:0];
    end

    rr_result_t rr;
    ic_rr_finder u_rr (
        .pend (pend_all),
        .last (last_q),
        .res  (rr)
    );
    assign next_valid_o = rr.valid;
    assign next_idx_o   = rr.idx;

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int b = 0; b < N_BANKS; b++) begin
                if (slot == SLOT_W'(b)) begin
                    case (sel)
                        REG_STATUS: bus_rdata = stat_w[b];
                        REG_ENABLE: bus_rdata = en_w[b];
                        REG_FAST:   bus_rdata = fast_w[b];
                        default:    bus_rdata = '0;
                    endcase
                end
            end
            if (last_hit)
                bus_rdata = DATA_W'(last_q);
        end
    end
endmodule

// File: rtl/ic_top_chk.sv
module ic_top_chk
    import ic_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] src_i,
    input logic [N_SRC-1:0] stat_all,
    input logic [N_SRC-1:0] en_all,
    input logic [N_SRC-1:0] fast_all,
    input logic [N_SRC-1:0] pend_all,
    input logic             irq_o,
    input logic             fiq_o,
    input logic             next_valid_o,
    input logic [IDX_W-1:0] next_idx_o
);
    logic [N_SRC-1:0] prev_src;
    logic [N_SRC-1:0] edges;

    always_ff @(posedge clk) begin
        if (rst)
            prev_src <= '0;
        else
            prev_src <= src_i;
    end
    assign edges = src_i & ~prev_src;

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_o && !fiq_o && !next_valid_o));

    p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (|edges) |=> ((stat_all & $past(edges)) == $past(edges)));

    p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|en_all));

    p_fiq_needs_route_r6: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (|(en_all & fast_all)));

    p_found_is_pending_r8: assert property (@(posedge clk) disable iff (rst)
        next_valid_o |-> pend_all[next_idx_o]);

    p_none_pending_r9: assert property (@(posedge clk) disable iff (rst)
        !next_valid_o |-> (pend_all == '0 && next_idx_o == '0));
endmodule

bind ic_top ic_top_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .src_i        (src_i),
    .stat_all     (stat_all),
    .en_all       (en_all),
    .fast_all     (fast_all),
    .pend_all     (pend_all),
    .irq_o        (irq_o),
    .fiq_o        (fiq_o),
    .next_valid_o (next_valid_o),
    .next_idx_o   (next_idx_o)
);

// File: tb/tb_ic_top.sv
`timescale 1ns/1ps
module tb_ic_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] src = '0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_o, fiq_o, next_valid_o;
    logic [6:0]   next_idx_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [127:0] m_stat = '0;
    logic [127:0] m_en   = '0;
    logic [127:0] m_fast = '0;
    logic [6:0]   m_last = 7'd127;

    always #5 clk = ~clk;

    ic_top dut (
        .clk          (clk),
        .rst          (rst),
        .src_i        (src),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_o        (irq_o),
        .fiq_o        (fiq_o),
        .next_valid_o (next_valid_o),
        .next_idx_o   (next_idx_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_w(input int a, input logic [31:0] d);
        bus_addr  = 8'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        bus_addr = 8'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input int k);
        src[k] = 1'b1;
        tick();
        src[k] = 1'b0;
        tick();
        m_stat[k] = 1'b1;
    endtask

    function automatic logic [7:0] exp_next();
        for (int s = 1; s <= 128; s++) begin
            int j;
            j = (int'(m_last) + s) % 128;
            if (m_stat[j] && m_en[j])
                return {1'b1, 7'(j)};
        end
        return 8'h00;
    endfunction

    task automatic chk_out(input string tag);
        logic [7:0] nx;
        #1;
        nx = exp_next();
        chk({tag, " irq"},   32'(irq_o),        32'(|(m_stat & m_en & ~m_fast)));
        chk({tag, " fiq"},   32'(fiq_o),        32'(|(m_stat & m_en & m_fast)));
        chk({tag, " valid"}, 32'(next_valid_o), 32'(nx[7]));
        chk({tag, " idx"},   32'(next_idx_o),   32'(nx[6:0]));
    endtask

    task automatic t_reset();
        for (int b = 0; b < 4; b++) begin
            rd_chk("R1 status", 16*b,     32'h0);
            rd_chk("R1 enable", 16*b + 8, 32'h0);
            rd_chk("R1 fast",   16*b + 12, 32'h0);
        end
        rd_chk("R1 last", 64, 32'd127);
        chk_out("R1/R9 reset outputs");
    endtask

    task automatic t_map();
        pulse(37);
        rd_chk("R2/R11 bank1 status", 16, 32'h0000_0020);
        rd_chk("R11 bank0 untouched", 0, 32'h0);
        chk_out("R5/R9 masked source");
    endtask

    task automatic t_enable();
        bus_w(24, 32'h0000_0020);
        m_en[63:32] = 32'h0000_0020;
        rd_chk("R5 enable readback", 24, 32'h0000_0020);
        chk_out("R5/R8 enabled source");
        chk("R5 irq high", 32'(irq_o), 32'h1);
        chk("R8 idx 37", 32'(next_idx_o), 32'd37);
    endtask

    task automatic t_fast();
        bus_w(28, 32'h0000_0020);
        m_fast[63:32] = 32'h0000_0020;
        chk_out("R6 routed fast");
        chk("R6 fiq high", 32'(fiq_o), 32'h1);
        chk("R6 irq low", 32'(irq_o), 32'h0);
    endtask

    task automatic t_status_ro();
        bus_w(16, 32'hFFFF_FFFF);
        bus_w(16, 32'h0);
        rd_chk("R7 status write ignored", 16, 32'h0000_0020);
    endtask

    task automatic t_clear();
        bus_w(20, 32'h0);
        rd_chk("R3 zero write keeps", 16, 32'h0000_0020);
        rd_chk("R3 clear reads zero", 20, 32'h0);
        bus_w(20, 32'h0000_0020);
        m_stat[37] = 1'b0;
        rd_chk("R3 bit cleared", 16, 32'h0);
        chk_out("R3 after clear");
    endtask

    task automatic t_race();
        pulse(70);
        src[70] = 1'b1;
        bus_w(36, 32'h0000_0040);
        src[70] = 1'b0;
        tick();
        rd_chk("R4 edge wins over clear", 32, 32'h0000_0040);
    endtask

    task automatic t_level();
        src[3] = 1'b1;
        tick();
        rd_chk("R2 edge sets bit3", 0, 32'h0000_0008);
        bus_w(4, 32'h0000_0008);
        tick();
        rd_chk("R2 held level no re-set", 0, 32'h0);
        src[3] = 1'b0;
        tick();
    endtask

    task automatic t_round_robin();
        for (int b = 0; b < 4; b++) bus_w(16*b + 8, 32'hFFFF_FFFF);
        m_en = '1;
        pulse(3);
        pulse(64);
        pulse(120);
        chk_out("R8 start at 0");
        chk("R8 first idx", 32'(next_idx_o), 32'd3);
        bus_w(64, 32'd3);  m_last = 7'd3;
        rd_chk("R10 last readback", 64, 32'd3);
        chk("R8 after 3", 32'(next_idx_o), 32'd64);
        bus_w(64, 32'd64); m_last = 7'd64;
        chk("R8 after 64", 32'(next_idx_o), 32'd70);
        bus_w(64, 32'd70); m_last = 7'd70;
        chk("R8 after 70", 32'(next_idx_o), 32'd120);
        bus_w(64, 32'd120); m_last = 7'd120;
        chk_out("R8 wrap");
        chk("R8 wrap idx", 32'(next_idx_o), 32'd3);
        bus_w(64, 32'hFFFF_FF02); m_last = 7'd2;
        rd_chk("R10 last 7 bits", 64, 32'd2);
        chk("R8 at-last+1 hit", 32'(next_idx_o), 32'd3);
        rd_chk("R10 unused offset", 68, 32'h0);
        rd_chk("R10 misaligned", 9, 32'h0);
    endtask

    task automatic t_none();
        for (int b = 0; b < 4; b++) bus_w(16*b + 4, 32'hFFFF_FFFF);
        m_stat = '0;
        chk_out("R9 none pending");
        chk("R9 valid low", 32'(next_valid_o), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        tick();
        t_reset();
        t_map();
        t_enable();
        t_fast();
        t_status_ro();
        t_clear();
        t_race();
        t_level();
        t_round_robin();
        t_none();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule